// File: doc/BRIEF.md
# Random Table Update Engine

The engine runs a random-access update workload against a table of 64-bit words held in an external single-port synchronous memory. A pulse on `start` captures a 64-bit seed and an update count. The engine first fills every table entry with its own index. It then repeats an update loop the requested number of times. Each pass advances a 64-bit pseudo-random value, takes the low address bits of that value as a table index, reads the entry, and writes it back XORed with the value.

The pseudo-random value follows a fixed rule. It is shifted left by one place, and the three lowest bits are then flipped if the old value was negative (sign bit set). Each update takes three memory cycles: read, wait and write. The next value is produced during the wait cycle. The memory returns read data one cycle after a read request. `busy` covers the whole run, and `done` marks its end.

Top module: `rand_update_engine`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `busy`, `done` and `mem_en` all low.
- R2: Each new value is the previous value shifted left by one bit, XORed with 7 when bit 63 of the previous value is 1, and with 0 otherwise. The first value used by an update is one step past the seed.
- R3: After an accepted `start`, the engine makes DEPTH write cycles (`mem_en`=1, `mem_we`=1) to addresses 0, 1, … DEPTH-1 in rising order. Each write stores the address zero-extended to 64 bits. No read happens before the last of these writes.
- R4: Update k (k = 1..N) addresses the entry selected by the low log2(DEPTH) bits of the k-th value after the seed.
- R5: Each update replaces the addressed entry with its old content XOR the value used for that update.
- R6: Each update is a read cycle (`mem_en`=1, `mem_we`=0), one wait cycle and a write cycle to the same address. `busy` is high for exactly DEPTH + 3·N cycles, beginning in the cycle after the accepted `start`.
- R7: `done` is high for exactly one cycle: the first cycle after the last write, in which `busy` is already low.
- R8: With a count of 0, only the initialisation writes happen. `done` then follows DEPTH cycles of `busy`.
- R9: `start` is ignored while `busy` is high. The seed, the count and the run length are not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| seed | input | 64 | Initial pseudo-random value |
| count | input | CNT_W | Number of updates |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | log2(DEPTH) | Table index |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid the cycle after a read request |

## Verification
A fault in the generator state shows up on `mem_addr` at the first read, DEPTH cycles after `start`. Its effect on the data only becomes visible in the table contents at the end of the run. A fault in the sequencer or the update counter changes the `busy` length, or the placement of the `done` pulse, by at least one cycle. A fault in the write-data path leaves a wrong table word. For that reason the full table is compared after every run, and the address order is checked during initialisation.

// File: rtl/rue_pkg.sv
package rue_pkg;

    localparam int WORD_W = 64;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_READ,
        ST_WAIT,
        ST_WRITE
    } rue_state_e;

    // One step of the sign-selected shift/XOR recurrence
    function automatic word_t rue_step(input word_t v);
        word_t mask;
        mask = v[WORD_W-1] ? word_t'(7) : word_t'(0);
        return {v[WORD_W-2:0], 1'b0} ^ mask;
    endfunction

endpackage

// File: rtl/rue_gen.sv
module rue_gen
    import rue_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t seed,
    input  logic  step,
    output word_t rnd
);

    always_ff @(posedge clk) begin
        if (rst)
            rnd <= '0;
        else if (load)
            rnd <= seed;
        else if (step)
            rnd <= rue_step(rnd);
    end

    // R2: new bit 0 equals the old sign bit (mask 7 vs 0)
    a_r2_mask_by_sign: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (rnd[0] == $past(rnd[WORD_W-1])));

    // R2: bits above the mask are a plain shift
    a_r2_shift_upper: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (rnd[WORD_W-1:3] == $past(rnd[WORD_W-2:2])));

endmodule

// File: rtl/rue_ctrl.sv
module rue_ctrl
    import rue_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    output rue_state_e       state,
    output logic [AW-1:0]    init_idx,
    output logic             gen_load,
    output logic             gen_step,
    output logic             busy,
    output logic             done
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [CNT_W-1:0] remain;
    logic             init_last;

    assign init_last = (init_idx == LAST_IDX);
    assign busy      = (state != ST_IDLE);
    assign gen_load  = (state == ST_IDLE) && start;
    assign gen_step  = ((state == ST_INIT) && init_last && (remain != '0))
                     || (state == ST_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            init_idx <= '0;
            remain   <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_INIT;
                        init_idx <= '0;
                        remain   <= count;
                    end
                end
                ST_INIT: begin
                    init_idx <= init_idx + 1'b1;
                    if (init_last) begin
                        if (remain == '0) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            state <= ST_READ;
                        end
                    end
                end
                ST_READ:  state <= ST_WAIT;
                ST_WAIT:  state <= ST_WRITE;
                ST_WRITE: begin
                    if (remain == CNT_W'(1)) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        state  <= ST_READ;
                        remain <= remain - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: a read is always followed by one wait and then a write
    a_r6_read_then_wait: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READ) |=> (state == ST_WAIT));
    a_r6_wait_then_write: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |=> (state == ST_WRITE));

    // R7: done lasts a single cycle, and busy is already low
    a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9: start while busy never restarts initialisation
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start && state != ST_INIT) |=> (state != ST_INIT));

    // R3: no read before initialisation has finished
    a_r3_init_before_read: assert property (@(posedge clk) disable iff (rst)
        (state == ST_INIT && !init_last) |=> (state == ST_INIT));

endmodule

// File: rtl/rue_memif.sv
module rue_memif
    import rue_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  rue_state_e    state,
    input  logic [AW-1:0] init_idx,
    input  word_t         rnd,
    input  word_t         mem_rdata,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output word_t         mem_wdata
);

    typedef struct packed {
        logic [AW-1:0] addr;
        word_t         data;
    } wr_req_t;

    wr_req_t pend;

    // Capture the merged word during the wait cycle
    always_ff @(posedge clk) begin
        if (rst)
            pend <= '0;
        else if (state == ST_WAIT)
            pend <= '{addr: rnd[AW-1:0], data: mem_rdata ^ rnd};
    end

    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_INIT: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = init_idx;
                mem_wdata = word_t'(init_idx);
            end
            ST_READ: begin
                mem_en   = 1'b1;
                mem_addr = rnd[AW-1:0];
            end
            ST_WRITE: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = pend.addr;
                mem_wdata = pend.data;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rand_update_engine.sv
module rand_update_engine
    import rue_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [63:0]      seed,
    input  logic [CNT_W-1:0] count,
    output logic             busy,
    output logic             done,
    output logic             mem_en,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [63:0]      mem_wdata,
    input  logic [63:0]      mem_rdata
);

    rue_state_e    state;
    logic [AW-1:0] init_idx;
    logic          gen_load;
    logic          gen_step;
    word_t         rnd;

    rue_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .count    (count),
        .state    (state),
        .init_idx (init_idx),
        .gen_load (gen_load),
        .gen_step (gen_step),
        .busy     (busy),
        .done     (done)
    );

    rue_gen u_gen (
        .clk  (clk),
        .rst  (rst),
        .load (gen_load),
        .seed (seed),
        .step (gen_step),
        .rnd  (rnd)
    );

    rue_memif #(.DEPTH(DEPTH)) u_memif (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .init_idx  (init_idx),
        .rnd       (rnd),
        .mem_rdata (mem_rdata),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    // R1: reset leaves the engine idle with the port quiet
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy && !done && !mem_en));

    // R4: the write of an update goes to the address read two cycles before
    a_r4_write_same_addr: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE) |-> (mem_addr == $past(mem_addr, 2)));

    // R6: the memory is never accessed in the wait cycle
    a_r6_wait_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |-> !mem_en);

endmodule

// File: tb/test_rand_update_engine.sv
module test_rand_update_engine;

    localparam int DEPTH = 16;
    localparam int CNT_W = 16;
    localparam int AW    = $clog2(DEPTH);
    localparam int NVEC  = 6;

    // {seed, count}
    localparam logic [79:0] VEC [NVEC] = '{
        {64'h0000_0000_0000_0001, 16'd5},
        {64'h8000_0000_0000_0000, 16'd20},
        {64'hFFFF_FFFF_FFFF_FFFF, 16'd33},
        {64'h0123_4567_89AB_CDEF, 16'd7},
        {64'h0000_0000_0000_0000, 16'd4},
        {64'hC3A5_5A3C_F00F_0FF0, 16'd200}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [63:0]      seed = '0;
    logic [CNT_W-1:0] count = '0;
    logic             busy, done, mem_en, mem_we;
    logic [AW-1:0]    mem_addr;
    logic [63:0]      mem_wdata;
    logic [63:0]      mem_rdata;

    logic [63:0] tbl [DEPTH];
    logic [63:0] expt [DEPTH];

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #4 clk = ~clk;   // 125 MHz

    rand_update_engine #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_rand_update_engine (
        .clk(clk), .rst(rst), .start(start), .seed(seed), .count(count),
        .busy(busy), .done(done), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Single-port synchronous memory, one-cycle read latency
    always @(posedge clk) begin
        if (mem_en && mem_we) tbl[mem_addr] <= mem_wdata;
        if (mem_en && !mem_we) mem_rdata <= tbl[mem_addr];
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=%0d exp<=150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [63:0] nxt(input logic [63:0] r);
        return (r << 1) ^ (r[63] ? 64'h7 : 64'h0);
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic build_expect(input logic [63:0] s, input int n);
        logic [63:0] r;
        for (int i = 0; i < DEPTH; i++) expt[i] = 64'(i);
        r = s;
        for (int k = 0; k < n; k++) begin
            r = nxt(r);
            expt[r[AW-1:0]] = expt[r[AW-1:0]] ^ r;
        end
    endtask

    // Run one job; optionally poke start mid-run with another seed
    task automatic run_job(input logic [63:0] s, input int n, input bit poke,
                           input string tag);
        int   cycles;
        int   wr_init;
        bit   init_ok;
        bit   seen_rd;
        logic [AW-1:0] first_rd;
        int   bad_idx;
        build_expect(s, n);
        @(negedge clk);
        seed  = s;
        count = CNT_W'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seed  = 64'hDEAD_BEEF_0BAD_F00D;
        count = CNT_W'(3);
        cycles = 1; wr_init = 0; init_ok = 1; seen_rd = 0; first_rd = '0;
        while (!done && cycles < 5000) begin
            if (!seen_rd && mem_en && mem_we) begin
                if (mem_addr != AW'(wr_init) || mem_wdata != 64'(wr_init)) init_ok = 0;
                wr_init++;
            end
            if (!seen_rd && mem_en && !mem_we) begin
                seen_rd = 1;
                first_rd = mem_addr;
            end
            if (poke && cycles == 6) start = 1'b1;
            if (poke && cycles == 7) start = 1'b0;
            if (poke && cycles == DEPTH + 2) start = 1'b1;
            if (poke && cycles == DEPTH + 3) start = 1'b0;
            @(negedge clk);
            cycles++;
        end
        start = 1'b0;
        // R6 / R8 / R9: run length
        chk(cycles == 1 + DEPTH + 3*n, {tag, " R6 busy length"},
            64'(cycles), 64'(1 + DEPTH + 3*n));
        chk(!busy, {tag, " R7 busy low at done"}, 64'(busy), 64'd0);
        // R3: init order and count
        chk(init_ok && wr_init == DEPTH, {tag, " R3 init writes"},
            64'(wr_init), 64'(DEPTH));
        // R2 / R4: first read address
        if (n > 0)
            chk(seen_rd && first_rd == nxt(s)[AW-1:0], {tag, " R4 first read addr"},
                64'(first_rd), 64'(nxt(s)[AW-1:0]));
        else
            chk(!seen_rd, {tag, " R8 no reads"}, 64'(seen_rd), 64'd0);
        // R5: table contents
        bad_idx = -1;
        for (int i = 0; i < DEPTH; i++)
            if (bad_idx < 0 && tbl[i] !== expt[i]) bad_idx = i;
        chk(bad_idx < 0, {tag, " R5 table contents"},
            (bad_idx < 0) ? 64'd0 : tbl[bad_idx],
            (bad_idx < 0) ? 64'd0 : expt[bad_idx]);
        @(negedge clk);
        chk(!done, {tag, " R7 done single cycle"}, 64'(done), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy,   "R1 busy in reset", 64'(busy), 64'd0);
        chk(!done,   "R1 done in reset", 64'(done), 64'd0);
        chk(!mem_en, "R1 mem_en in reset", 64'(mem_en), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy, "R1 idle after reset", 64'(busy), 64'd0);

        // Vector table: R2 R4 R5 R6 under several seeds and counts
        for (int v = 0; v < NVEC; v++)
            run_job(VEC[v][79:16], int'(VEC[v][15:0]), 1'b0, "vec");

        // R8: zero count
        run_job(64'h1234_5678_9ABC_DEF0, 0, 1'b0, "zero");

        // R9: start while busy ignored
        run_job(64'h8000_0000_0000_0003, 9, 1'b1, "poke");

        // R1: reset in mid-run returns to idle
        @(negedge clk);
        seed = 64'h5; count = CNT_W'(50); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (DEPTH + 4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy && !mem_en && !done, "R1 mid-run reset",
            {61'd0, busy, mem_en, done}, 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule